// File: doc/BRIEF.md
# Packet Boundary Alignment Tracker

This block finds packet framing on a word-wide bus that carries no start-of-packet marker. While the link is idle the far end sends all-ones filler words, which count as no-operation packets. The block discards these as long as it is searching. The first word that differs from all ones is taken as word zero of a packet. From then on a wrapping word counter marks every packet start, and the incoming data no longer affects the framing.

Once the inbound framing is fixed, the block waits one full packet period. It then drives a fixed response packet on its transmit output, which lets the far end frame the return direction. It sends all-ones filler at every other time. Framing is kept as long as the clocks run. A reset or a clock-loss indication puts the block back into the search, and the search starts again from idle filler.

Top module: `pkt_frame_align`

## Requirements
- R1: While reset is asserted, `aligned` and `pkt_start` are low and `tx_word` is all ones.
- R2: While not aligned, an all-ones `rx_word` leaves `aligned` low and produces no `pkt_start`.
- R3: A non-all-ones `rx_word` sampled while not aligned raises `aligned` and `pkt_start` together on the following cycle; that word is word 0 of a packet.
- R4: Once aligned, `pkt_start` is a one-cycle pulse that repeats every `PKT_WORDS` cycles, counting from the first pulse.
- R5: Once aligned, the value of `rx_word` (filler or data) has no effect on `pkt_start`, `aligned` or `tx_word`.
- R6: The response packet is `PKT_WORDS` consecutive words, word k equal to `RESP_SEED + k`. Word 0 appears on `tx_word` in the same cycle as the second `pkt_start` after alignment.
- R7: Outside the response packet, `tx_word` is all ones. The response is sent only once per alignment.
- R8: A high `clk_lost` sampled at a clock edge gives `aligned` low, `pkt_start` low and `tx_word` all ones on the next cycle. It cuts off any response in progress and has priority over a non-all-ones `rx_word` in the same cycle.
- R9: After a return to the search, the next alignment sends the full response packet again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_lost | input | 1 | Synchronous indication that the bus clocks stopped; forces a new search |
| rx_word | input | WORD_W | Incoming bus word, one per cycle |
| tx_word | output | WORD_W | Outgoing bus word: filler or response packet |
| pkt_start | output | 1 | One-cycle pulse marking the cycle after word 0 of an inbound packet was sampled |
| aligned | output | 1 | Inbound framing established |

## Verification
The hardest state to reach from the ports is a clock loss that arrives partway through the response packet, followed by a fresh alignment. The bench has to land the drop exactly between the response's first and last words. It must then show that the cut-off response is not resumed and that the new alignment sends a complete response from word 0. The stimulus locks with a chosen word and counts a fixed number of cycles past the first packet period before raising `clk_lost`. It then relocks after a few filler words. Long aligned stretches mix filler and data words, so that ignoring `rx_word` is visible on every output.

// File: rtl/pfa_pkg.sv
package pfa_pkg;

   typedef enum logic {
      FR_SEARCH = 1'b0,
      FR_LOCKED = 1'b1
   } frame_state_e;

   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/pfa_filler_detect.sv
module pfa_filler_detect #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned LANE_W = 8
) (
   input  logic [WORD_W-1:0] word_i,
   output logic              is_filler_o
);

   localparam bit USE_LANES = (WORD_W > LANE_W) && ((WORD_W % LANE_W) == 0);
   localparam int unsigned N_LANES = USE_LANES ? (WORD_W / LANE_W) : 1;

   generate
      if (USE_LANES) begin : g_lanes
         logic [N_LANES-1:0] lane_ones;
         for (genvar g = 0; g < N_LANES; g++) begin : g_lane
            assign lane_ones[g] = &word_i[g*LANE_W +: LANE_W];
         end
         assign is_filler_o = &lane_ones;
      end else begin : g_flat
         assign is_filler_o = &word_i;
      end
   endgenerate

endmodule

// File: rtl/pfa_slot_counter.sv
module pfa_slot_counter #(
   parameter int unsigned PKT_WORDS = 4,
   parameter int unsigned CNT_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             load_i,
   input  logic             run_i,
   output logic [CNT_W-1:0] slot_o,
   output logic             at_first_o
);

   localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(PKT_WORDS - 1);
   localparam logic [CNT_W-1:0] SLOT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (clear_i) begin
         slot_q <= '0;
      end else if (load_i) begin
         slot_q <= SLOT_ONE;
      end else if (run_i) begin
         slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + SLOT_ONE;
      end
   end

   assign slot_o     = slot_q;
   assign at_first_o = (slot_q == '0);

endmodule

// File: rtl/pfa_resp_tx.sv
module pfa_resp_tx #(
   parameter int unsigned       WORD_W    = 16,
   parameter int unsigned       PKT_WORDS = 4,
   parameter logic [WORD_W-1:0] RESP_SEED = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort_i,
   input  logic              start_i,
   output logic [WORD_W-1:0] tx_o
);

   localparam int unsigned KW = $clog2(PKT_WORDS + 1);
   localparam logic [KW-1:0] K_END = KW'(PKT_WORDS);
   localparam logic [WORD_W-1:0] FILLER = '1;
   localparam int unsigned TABLE_MAX = 16;

   logic [KW-1:0]     k_q;
   logic              busy_q;
   logic [WORD_W-1:0] tx_q;
   logic [WORD_W-1:0] next_word;

   generate
      if (PKT_WORDS <= TABLE_MAX) begin : g_table
         logic [WORD_W-1:0] words [PKT_WORDS];
         for (genvar g = 0; g < PKT_WORDS; g++) begin : g_w
            assign words[g] = RESP_SEED + WORD_W'(g);
         end
         always_comb begin
            next_word = FILLER;
            for (int i = 0; i < PKT_WORDS; i++) begin
               if (k_q == KW'(i)) next_word = words[i];
            end
         end
      end else begin : g_adder
         assign next_word = RESP_SEED + WORD_W'(k_q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k_q    <= '0;
         busy_q <= 1'b0;
         tx_q   <= FILLER;
      end else if (abort_i) begin
         k_q    <= '0;
         busy_q <= 1'b0;
         tx_q   <= FILLER;
      end else if (start_i) begin
         k_q    <= KW'(1);
         busy_q <= 1'b1;
         tx_q   <= RESP_SEED;
      end else if (busy_q && (k_q < K_END)) begin
         k_q    <= k_q + KW'(1);
         tx_q   <= next_word;
      end else begin
         k_q    <= '0;
         busy_q <= 1'b0;
         tx_q   <= FILLER;
      end
   end

   assign tx_o = tx_q;

endmodule

// File: rtl/pkt_frame_align.sv
module pkt_frame_align #(
   parameter int unsigned       WORD_W    = 16,
   parameter int unsigned       PKT_WORDS = 4,
   parameter int unsigned       LANE_W    = 8,
   parameter logic [WORD_W-1:0] RESP_SEED = 16'h0A50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_lost,
   input  logic [WORD_W-1:0] rx_word,
   output logic [WORD_W-1:0] tx_word,
   output logic              pkt_start,
   output logic              aligned
);
   import pfa_pkg::*;

   localparam int unsigned CNT_W = cnt_bits(PKT_WORDS);
   localparam logic [WORD_W:0] RESP_LAST = {1'b0, RESP_SEED} + (WORD_W+1)'(PKT_WORDS - 1);
   localparam logic [WORD_W:0] ALL_ONES_X = {1'b0, {WORD_W{1'b1}}};

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("pkt_frame_align: WORD_W must be at least 2");
      end
      if (PKT_WORDS < 2) begin : g_bad_len
         $error("pkt_frame_align: PKT_WORDS must be at least 2");
      end
      if (LANE_W < 1) begin : g_bad_lane
         $error("pkt_frame_align: LANE_W must be at least 1");
      end
      if (RESP_LAST >= ALL_ONES_X) begin : g_bad_seed
         $error("pkt_frame_align: response words must stay below all ones");
      end
   endgenerate

   frame_state_e     state_q;
   logic             rx_filler;
   logic [CNT_W-1:0] slot;
   logic             at_first;
   logic             found;
   logic             locked;
   logic             boundary;
   logic             resp_done_q;
   logic             resp_go;
   logic             pkt_start_q;

   pfa_filler_detect #(
      .WORD_W (WORD_W),
      .LANE_W (LANE_W)
   ) u_detect (
      .word_i      (rx_word),
      .is_filler_o (rx_filler)
   );

   assign locked   = (state_q == FR_LOCKED);
   assign found    = !locked && !rx_filler && !clk_lost;
   assign boundary = locked && at_first && !clk_lost;
   assign resp_go  = boundary && !resp_done_q;

   pfa_slot_counter #(
      .PKT_WORDS (PKT_WORDS),
      .CNT_W     (CNT_W)
   ) u_slots (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (clk_lost),
      .load_i     (found),
      .run_i      (locked),
      .slot_o     (slot),
      .at_first_o (at_first)
   );

   pfa_resp_tx #(
      .WORD_W    (WORD_W),
      .PKT_WORDS (PKT_WORDS),
      .RESP_SEED (RESP_SEED)
   ) u_resp (
      .clk     (clk),
      .rst_n   (rst_n),
      .abort_i (clk_lost),
      .start_i (resp_go),
      .tx_o    (tx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= FR_SEARCH;
         resp_done_q <= 1'b0;
         pkt_start_q <= 1'b0;
      end else begin
         pkt_start_q <= found || boundary;
         if (clk_lost) begin
            state_q     <= FR_SEARCH;
            resp_done_q <= 1'b0;
         end else begin
            if (found) state_q <= FR_LOCKED;
            if (resp_go) resp_done_q <= 1'b1;
         end
      end
   end

   assign pkt_start = pkt_start_q;
   assign aligned   = locked;

endmodule

// File: rtl/pfa_chk.sv
module pfa_chk #(
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned PKT_WORDS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_lost,
   input logic [WORD_W-1:0] rx_word,
   input logic [WORD_W-1:0] tx_word,
   input logic              pkt_start,
   input logic              aligned
);

   logic [15:0] gap_q;
   logic        seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         if (pkt_start) gap_q <= '0;
         else if (gap_q != 16'hFFFF) gap_q <= gap_q + 16'd1;
         if (!aligned) seen_q <= 1'b0;
         else if (pkt_start) seen_q <= 1'b1;
      end
   end

   // R2 R7
   filler_when_unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !aligned |-> (tx_word == {WORD_W{1'b1}}));

   // R3
   strobe_needs_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_start |-> aligned);

   // R3
   lock_on_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!aligned && !clk_lost && (rx_word != {WORD_W{1'b1}})) |=> (aligned && pkt_start));

   // R2
   stay_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!aligned && (rx_word == {WORD_W{1'b1}})) |=> (!aligned && !pkt_start));

   // R4
   period_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_start && seen_q) |-> (gap_q == 16'(PKT_WORDS - 1)));

   // R4
   period_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (aligned && seen_q && !pkt_start && (gap_q == 16'(PKT_WORDS - 1))) |-> 1'b0);

   // R5
   hold_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (aligned && !clk_lost) |=> aligned);

   // R8
   loss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_lost |=> (!aligned && !pkt_start && (tx_word == {WORD_W{1'b1}})));

endmodule

bind pkt_frame_align pfa_chk #(
   .WORD_W    (WORD_W),
   .PKT_WORDS (PKT_WORDS)
) u_pfa_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clk_lost  (clk_lost),
   .rx_word   (rx_word),
   .tx_word   (tx_word),
   .pkt_start (pkt_start),
   .aligned   (aligned)
);

// File: tb/tb_pkt_frame_align.sv
`timescale 1ns/1ps
module tb_pkt_frame_align;

   localparam int unsigned W = 16;
   localparam int unsigned N = 4;
   localparam logic [W-1:0] SEED = 16'h0A50;
   localparam logic [W-1:0] ONES = '1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         clk_lost = 1'b0;
   logic [W-1:0] rx_word = '1;
   logic [W-1:0] tx_word;
   logic         pkt_start;
   logic         aligned;

   pkt_frame_align #(
      .WORD_W    (W),
      .PKT_WORDS (N),
      .LANE_W    (8),
      .RESP_SEED (SEED)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_lost  (clk_lost),
      .rx_word   (rx_word),
      .tx_word   (tx_word),
      .pkt_start (pkt_start),
      .aligned   (aligned)
   );

   always #2 clk = ~clk;

   typedef struct {
      int           due;
      logic         al;
      logic         ps;
      logic [W-1:0] tx;
      string        tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_checks = 0;
   int   n_errs = 0;
   bit   done = 1'b0;

   // reference state built from the requirements
   bit   m_al = 0;
   int   m_idx = 0;
   int   m_rk = 0;
   bit   m_sent = 0;
   int   m_locks = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check1(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   task automatic step(input logic [W-1:0] w, input bit lost);
      exp_t e;
      @(posedge clk);
      #1;
      rx_word  = w;
      clk_lost = lost;
      if (lost) begin
         m_al = 0; m_idx = 0; m_rk = 0; m_sent = 0;
         e.ps = 0; e.tx = ONES; e.tag = "R8";
      end else if (!m_al) begin
         e.tx = ONES;
         if (w != ONES) begin
            m_al = 1; m_idx = 1; m_locks++;
            e.ps = 1; e.tag = "R3";
         end else begin
            e.ps = 0; e.tag = "R2";
         end
      end else begin
         e.ps = (m_idx == 0);
         if (e.ps && !m_sent) begin
            e.tx = SEED; m_rk = 1; m_sent = 1;
         end else if (m_rk != 0 && m_rk < N) begin
            e.tx = SEED + W'(m_rk); m_rk++;
         end else begin
            e.tx = ONES; m_rk = 0;
         end
         m_idx = (m_idx + 1) % N;
         if (e.tx != ONES) e.tag = (m_locks > 1) ? "R9" : "R6";
         else e.tag = e.ps ? "R4" : "R5/R7";
      end
      e.al  = m_al;
      e.due = cyc + 1;
      q.push_back(e);
   endtask

   // monitor: compare at the falling edge once the item's cycle has come
   initial begin
      forever begin
         @(negedge clk);
         while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            check1(e.tag, "aligned", W'(aligned), W'(e.al));
            check1(e.tag, "pkt_start", W'(pkt_start), W'(e.ps));
            check1(e.tag, "tx_word", tx_word, e.tx);
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_checks++;
         n_errs++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   initial begin
      // R1: state held in reset, even with data on the input
      repeat (2) @(posedge clk);
      #1 rx_word = 16'h1357;
      @(negedge clk);
      check1("R1", "aligned", W'(aligned), W'(0));
      check1("R1", "pkt_start", W'(pkt_start), W'(0));
      check1("R1", "tx_word", tx_word, ONES);
      @(posedge clk);
      #1 rx_word = ONES;
      rst_n = 1'b1;

      // R2: idle filler keeps the search going
      repeat (5) step(ONES, 0);
      // R3: first data word locks
      step(16'h1234, 0);
      // R4 R5 R6 R7: long aligned stretch, mixed filler and data
      for (int i = 0; i < 4 * N + 1; i++)
         step((i % 3 == 0) ? ONES : W'(i * 37 + 5), 0);
      // R8: loss, then loss together with data
      step(ONES, 1);
      step(16'h00FF, 1);
      repeat (3) step(ONES, 0);
      // R8: relock, drop partway through the response
      step(16'hBEEF, 0);
      for (int i = 0; i < N + 1; i++) step(W'(i + 16'h0100), 0);
      step(16'h4444, 1);
      step(ONES, 0);
      // R9: relock on an all-zero word, full response again
      step(16'h0000, 0);
      for (int i = 0; i < 3 * N; i++) step((i % 2 == 0) ? W'(16'hA000 + i) : ONES, 0);

      repeat (4) @(posedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

endmodule